// File: doc/BRIEF.md
# SONET Section Overhead Generator

This block sits in the transmit path of one STS-1/STM-0 stream. It takes one byte per clock and a start-of-frame marker. It rebuilds the section overhead of each 9-row by 90-column frame and puts the result out one clock later. Each overhead group has its own control that picks between a locally generated byte and the incoming byte. The groups are framing (A1/A2), trace (J0), parity (B1), user channel (F1), data communication (D1-D3) and the reserved/orderwire byte.

For test, errors can be forced into the framing pattern and into the parity byte. Line AIS can be forced by a manual input, or raised automatically from loss-of-frame or loss-of-signal inputs. A frame-synchronous scrambler covers everything except the first three bytes of row 0. The J0 trace comes from a writable 64-entry table and is sent as a 16-byte or a 64-byte repeating sequence.

In this brief, rows and columns are numbered from 0. The position counter restarts at row 0, column 0 on every byte that carries the start marker.

Top module: `soh_gen`

## Requirements
- R1: `out_data`/`out_fs` follow the input byte by exactly one clock, and `out_fs` copies `in_fs`. A byte with `in_fs`=1 is taken as row 0, column 0, whatever the previous count was. After reset both outputs are 0.
- R2: With `regen_a1a2`=1, row 0 column 0 becomes 0xF6 and row 0 column 1 becomes 0x28. With `regen_a1a2`=0, both bytes pass through unchanged.
- R3: With `frm_err`=1, bit 0 of the row 0 column 0 byte is inverted after the R2 selection.
- R4: With `regen_j0`=1, row 0 column 2 carries trace table entry `idx`. A write through `trace_we`/`trace_addr`/`trace_wdata` takes effect from the next clock. `idx` starts at 0 and advances once per J0 byte. It wraps after 15 when `j0_short`=1 and after 63 when `j0_short`=0. With `regen_j0`=0, J0 passes through.
- R5: While line AIS is active and `rs_ais_en`=1, J0 is 0xFF. This rule takes priority over R4.
- R6: With `regen_b1`=1, row 1 column 0 carries the even-parity XOR of every output byte of the previous frame, placed before scrambling. With `regen_b1`=0, the input byte passes through. The previous frame runs from the last row 0 column 0 up to the byte before the current one.
- R7: With `b1_err`=1, bit 0 of the B1 byte is inverted before scrambling.
- R8: With `regen_f1`=1, row 1 column 2 becomes 0x00. Otherwise it passes through.
- R9: With `regen_dcc`=1, row 2 columns 0-2 become 0x00. Otherwise they pass through.
- R10: With `regen_rsv`=1, row 1 column 1 becomes 0x00. Otherwise it passes through.
- R11: Line AIS is active when `ais_man`=1, or when `ais_auto_en`=1 and `lof` or `los` is 1. While it is active, every byte outside rows 0-2 columns 0-2 is 0xFF before scrambling. With `ais_auto_en`=0, `lof` and `los` have no effect.
- R12: With `scr_en`=1, every byte except row 0 columns 0-2 is XORed with the 1+x^6+x^7 sequence. The sequence is taken MSB first and restarts from all ones at row 0 column 3, so that byte uses key 0xFE. With `scr_en`=0, no byte is changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Incoming frame byte |
| in_fs | input | 1 | Marks row 0 column 0 |
| regen_a1a2 | input | 1 | Generate framing bytes |
| regen_j0 | input | 1 | Generate J0 from trace table |
| regen_b1 | input | 1 | Generate B1 parity |
| regen_f1 | input | 1 | Generate F1 |
| regen_dcc | input | 1 | Generate D1-D3 |
| regen_rsv | input | 1 | Generate reserved byte |
| frm_err | input | 1 | Corrupt first A1 |
| b1_err | input | 1 | Corrupt B1 |
| ais_man | input | 1 | Force line AIS |
| ais_auto_en | input | 1 | Allow lof/los to raise AIS |
| lof | input | 1 | Loss-of-frame defect |
| los | input | 1 | Loss-of-signal defect |
| rs_ais_en | input | 1 | J0=0xFF during AIS |
| j0_short | input | 1 | 1: 16-byte trace, 0: 64-byte trace |
| scr_en | input | 1 | Scrambler enable |
| trace_we | input | 1 | Trace table write strobe |
| trace_addr | input | 6 | Trace table write address |
| trace_wdata | input | 8 | Trace table write data |
| out_data | output | 8 | Outgoing frame byte |
| out_fs | output | 1 | Delayed frame marker |

## Verification
The hardest condition to reach is a 64-byte trace wrap: it needs more than 64 complete frames with `j0_short` held at 0. The stimulus therefore runs an unbroken stretch of 66 frames in that mode after the trace table has been filled with random bytes. It also restarts the frame marker part-way through a frame. This checks that the position count and the parity window resynchronise correctly.

// File: rtl/sohg_pkg.sv
package sohg_pkg;

    localparam logic [7:0] A1_VAL   = 8'hF6;
    localparam logic [7:0] A2_VAL   = 8'h28;
    localparam logic [7:0] FILL_VAL = 8'h00;
    localparam logic [7:0] AIS_VAL  = 8'hFF;
    localparam logic [6:0] SCR_SEED = 7'h7F;
    localparam int         OH_COLS  = 3;

    typedef enum logic [2:0] {
        K_BODY, K_A1, K_A2, K_J0, K_B1, K_RSV, K_F1, K_DCC
    } oh_kind_e;

    typedef struct packed {
        logic [7:0] data;
        logic       fs;
    } out_t;

    // Keystream byte, MSB first, from a 1+x^6+x^7 register state
    function automatic logic [7:0] scr_key(input logic [6:0] st);
        logic [6:0] s;
        logic [7:0] k;
        s = st;
        k = '0;
        for (int i = 7; i >= 0; i--) begin
            k[i] = s[6];
            s    = {s[5:0], s[6] ^ s[5]};
        end
        return k;
    endfunction

    function automatic logic [6:0] scr_step8(input logic [6:0] st);
        logic [6:0] s;
        s = st;
        for (int i = 0; i < 8; i++) begin
            s = {s[5:0], s[6] ^ s[5]};
        end
        return s;
    endfunction

endpackage

// File: rtl/sohg_pos.sv
module sohg_pos #(
    parameter  int ROWS = 9,
    parameter  int COLS = 90,
    localparam int RW   = $clog2(ROWS),
    localparam int CW   = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof,
    output logic [RW-1:0] cur_row,
    output logic [CW-1:0] cur_col
);

    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        cur_row = sof ? '0 : pos_q.row;
        cur_col = sof ? '0 : pos_q.col;
        pos_d   = pos_q;
        if (cur_col == CW'(COLS - 1)) begin
            pos_d.col = '0;
            pos_d.row = (cur_row == RW'(ROWS - 1)) ? '0 : cur_row + 1'b1;
        end else begin
            pos_d.col = cur_col + 1'b1;
            pos_d.row = cur_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    // R1: a frame marker restarts the count at column 0 of row 0
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (pos_q.row == '0 && pos_q.col == CW'(1)));

endmodule

// File: rtl/sohg_trace.sv
module sohg_trace #(
    parameter  int DEPTH = 64,
    parameter  int SHORT = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          adv,
    input  logic          short_mode,
    output logic [7:0]    rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         idx;
    } trace_t;

    trace_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.mem[waddr] = wdata;
        if (adv) begin
            if (short_mode && st_q.idx >= AW'(SHORT - 1))
                st_d.idx = '0;
            else if (st_q.idx == AW'(DEPTH - 1))
                st_d.idx = '0;
            else
                st_d.idx = st_q.idx + 1'b1;
        end
        rdata = st_q.mem[st_q.idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: short mode keeps the index inside the first SHORT entries
    a_r4_short_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && short_mode) |=> (st_q.idx < AW'(SHORT)));

    // R4: the index moves only on a J0 byte
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> (st_q.idx == $past(st_q.idx)));

endmodule

// File: rtl/sohg_scr.sv
module sohg_scr
    import sohg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       seed_now,
    input  logic       adv,
    input  logic [7:0] tx_byte,
    output logic [7:0] key,
    output logic [7:0] b1
);

    typedef struct packed {
        logic [6:0] lfsr;
        logic [7:0] acc;
        logic [7:0] b1;
    } scr_t;

    scr_t st_d, st_q;
    logic [6:0] base;

    always_comb begin
        st_d = st_q;
        base = seed_now ? SCR_SEED : st_q.lfsr;
        key  = scr_key(base);
        if (adv) st_d.lfsr = scr_step8(base);
        if (frame_start) begin
            st_d.b1  = st_q.acc;
            st_d.acc = tx_byte;
        end else begin
            st_d.acc = st_q.acc ^ tx_byte;
        end
        b1 = st_q.b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lfsr <= SCR_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: the parity result changes only at a frame start
    a_r6_b1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> (b1 == $past(b1)));

endmodule

// File: rtl/soh_gen.sv
module soh_gen
    import sohg_pkg::*;
#(
    parameter  int ROWS        = 9,
    parameter  int COLS        = 90,
    parameter  int TRACE_DEPTH = 64,
    parameter  int TRACE_SHORT = 16,
    localparam int TAW         = $clog2(TRACE_DEPTH),
    localparam int RW          = $clog2(ROWS),
    localparam int CW          = $clog2(COLS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [7:0]     in_data,
    input  logic           in_fs,
    input  logic           regen_a1a2,
    input  logic           regen_j0,
    input  logic           regen_b1,
    input  logic           regen_f1,
    input  logic           regen_dcc,
    input  logic           regen_rsv,
    input  logic           frm_err,
    input  logic           b1_err,
    input  logic           ais_man,
    input  logic           ais_auto_en,
    input  logic           lof,
    input  logic           los,
    input  logic           rs_ais_en,
    input  logic           j0_short,
    input  logic           scr_en,
    input  logic           trace_we,
    input  logic [TAW-1:0] trace_addr,
    input  logic [7:0]     trace_wdata,
    output logic [7:0]     out_data,
    output logic           out_fs
);

    logic [RW-1:0] cur_row;
    logic [CW-1:0] cur_col;
    logic [7:0]    trace_byte, key, b1_val, pre_byte;
    logic          ais_on, hdr_zone, frame_start, seed_now;
    oh_kind_e      kind;
    out_t          out_d, out_q;

    sohg_pos #(.ROWS(ROWS), .COLS(COLS)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (in_fs),
        .cur_row (cur_row),
        .cur_col (cur_col)
    );

    sohg_trace #(.DEPTH(TRACE_DEPTH), .SHORT(TRACE_SHORT)) u_trace (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (trace_we),
        .waddr      (trace_addr),
        .wdata      (trace_wdata),
        .adv        (kind == K_J0),
        .short_mode (j0_short),
        .rdata      (trace_byte)
    );

    sohg_scr u_scr (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .seed_now    (seed_now),
        .adv         (!hdr_zone),
        .tx_byte     (out_d.data),
        .key         (key),
        .b1          (b1_val)
    );

    always_comb begin
        ais_on      = ais_man | (ais_auto_en & (lof | los));
        frame_start = (cur_row == '0) && (cur_col == '0);
        seed_now    = (cur_row == '0) && (cur_col == CW'(OH_COLS));
        hdr_zone    = (cur_row == '0) && (cur_col < CW'(OH_COLS));
        kind        = K_BODY;
        if (cur_col < CW'(OH_COLS)) begin
            case (cur_row)
                RW'(0): kind = (cur_col == '0) ? K_A1 :
                               (cur_col == CW'(1)) ? K_A2 : K_J0;
                RW'(1): kind = (cur_col == '0) ? K_B1 :
                               (cur_col == CW'(1)) ? K_RSV : K_F1;
                RW'(2): kind = K_DCC;
                default: kind = K_BODY;
            endcase
        end

        case (kind)
            K_A1:    pre_byte = (regen_a1a2 ? A1_VAL : in_data) ^ {7'b0, frm_err};
            K_A2:    pre_byte = regen_a1a2 ? A2_VAL : in_data;
            K_J0:    pre_byte = (ais_on && rs_ais_en) ? AIS_VAL :
                                (regen_j0 ? trace_byte : in_data);
            K_B1:    pre_byte = (regen_b1 ? b1_val : in_data) ^ {7'b0, b1_err};
            K_RSV:   pre_byte = regen_rsv ? FILL_VAL : in_data;
            K_F1:    pre_byte = regen_f1 ? FILL_VAL : in_data;
            K_DCC:   pre_byte = regen_dcc ? FILL_VAL : in_data;
            default: pre_byte = ais_on ? AIS_VAL : in_data;
        endcase

        out_d.data = (scr_en && !hdr_zone) ? (pre_byte ^ key) : pre_byte;
        out_d.fs   = in_fs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_data = out_q.data;
    assign out_fs   = out_q.fs;

    // R1: marker delayed by one clock
    a_r1_fs_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_fs |=> out_fs);

    // R2: generated A2 value
    a_r2_a2_value: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_A2 && regen_a1a2) |=> (out_data == 8'h28));

    // R3: corrupted A1 value
    a_r3_a1_corrupt: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_A1 && regen_a1a2 && frm_err) |=> (out_data == 8'hF7));

    // R5: trace forced to all ones during AIS
    a_r5_rs_ais: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_J0 && ais_on && rs_ais_en) |=> (out_data == 8'hFF));

    // R11: body filled with ones during AIS when unscrambled
    a_r11_ais_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_BODY && ais_on && !scr_en) |=> (out_data == 8'hFF));

endmodule

// File: tb/soh_gen_tb.sv
module soh_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS       = 9;
    localparam int COLS       = 90;
    localparam int FRAME      = ROWS * COLS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_fs = 1'b0;
    logic regen_a1a2 = 0, regen_j0 = 0, regen_b1 = 0, regen_f1 = 0;
    logic regen_dcc = 0, regen_rsv = 0, frm_err = 0, b1_err = 0;
    logic ais_man = 0, ais_auto_en = 0, lof = 0, los = 0, rs_ais_en = 0;
    logic j0_short = 1, scr_en = 1, trace_we = 0;
    logic [5:0] trace_addr = '0;
    logic [7:0] trace_wdata = '0;
    logic [7:0] out_data;
    logic       out_fs;

    soh_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_fs(in_fs),
        .regen_a1a2(regen_a1a2), .regen_j0(regen_j0), .regen_b1(regen_b1),
        .regen_f1(regen_f1), .regen_dcc(regen_dcc), .regen_rsv(regen_rsv),
        .frm_err(frm_err), .b1_err(b1_err), .ais_man(ais_man),
        .ais_auto_en(ais_auto_en), .lof(lof), .los(los), .rs_ais_en(rs_ais_en),
        .j0_short(j0_short), .scr_en(scr_en), .trace_we(trace_we),
        .trace_addr(trace_addr), .trace_wdata(trace_wdata),
        .out_data(out_data), .out_fs(out_fs)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state
    int         m_row = 0, m_col = 0, m_idx = 0, g_pos = 0;
    logic [6:0] m_lfsr = 7'h7F;
    logic [7:0] m_acc = '0, m_b1 = '0;
    logic [7:0] m_trace [64];
    logic [7:0] exp_data;
    logic       exp_fs;
    string      exp_req;

    function automatic logic [7:0] key_of(input logic [6:0] st);
        logic [6:0] r = st;
        logic [7:0] k = '0;
        for (int n = 0; n < 8; n++) begin
            k = {k[6:0], r[6]};
            r = {r[5:0], r[6] ^ r[5]};
        end
        return k;
    endfunction

    function automatic logic [6:0] next_of(input logic [6:0] st);
        logic [6:0] r = st;
        for (int n = 0; n < 8; n++) r = {r[5:0], r[6] ^ r[5]};
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [8:0] act,
                         input logic [8:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic model_step();
        int r, c;
        logic [7:0] b;
        logic [6:0] s;
        bit ais;
        string req;
        r   = in_fs ? 0 : m_row;
        c   = in_fs ? 0 : m_col;
        ais = ais_man || (ais_auto_en && (lof || los));
        req = ais ? "R11" : (scr_en ? "R12" : "R1");
        b   = ais ? 8'hFF : in_data;
        if (r == 0 && c == 0) begin
            b = regen_a1a2 ? 8'hF6 : in_data; req = "R2";
            if (frm_err) begin b ^= 8'h01; req = "R3"; end
        end else if (r == 0 && c == 1) begin
            b = regen_a1a2 ? 8'h28 : in_data; req = "R2";
        end else if (r == 0 && c == 2) begin
            if (ais && rs_ais_en) begin b = 8'hFF; req = "R5"; end
            else begin b = regen_j0 ? m_trace[m_idx] : in_data; req = "R4"; end
            if (j0_short && m_idx >= 15) m_idx = 0;
            else if (m_idx == 63) m_idx = 0;
            else m_idx++;
        end else if (r == 1 && c == 0) begin
            b = regen_b1 ? m_b1 : in_data; req = "R6";
            if (b1_err) begin b ^= 8'h01; req = "R7"; end
        end else if (r == 1 && c == 1) begin
            b = regen_rsv ? 8'h00 : in_data; req = "R10";
        end else if (r == 1 && c == 2) begin
            b = regen_f1 ? 8'h00 : in_data; req = "R8";
        end else if (r == 2 && c < 3) begin
            b = regen_dcc ? 8'h00 : in_data; req = "R9";
        end
        if (!(r == 0 && c < 3)) begin
            s = (r == 0 && c == 3) ? 7'h7F : m_lfsr;
            if (scr_en) b ^= key_of(s);
            m_lfsr = next_of(s);
        end
        if (r == 0 && c == 0) begin m_b1 = m_acc; m_acc = b; end
        else m_acc ^= b;
        if (trace_we) m_trace[trace_addr] = trace_wdata;
        c++;
        if (c == COLS) begin c = 0; r = (r == ROWS - 1) ? 0 : r + 1; end
        m_row = r; m_col = c;
        exp_data = b; exp_fs = in_fs; exp_req = req;
    endtask

    task automatic send(input logic [7:0] d);
        in_data = d;
        in_fs   = (g_pos == 0);
        g_pos   = (g_pos + 1) % FRAME;
        model_step();
        @(negedge clk);
        check(out_data == exp_data && out_fs == exp_fs, exp_req,
              {out_fs, out_data}, {exp_fs, exp_data});
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n * FRAME; i++) send(8'($urandom));
    endtask

    task automatic set_regen(input bit v);
        regen_a1a2 = v; regen_j0 = v; regen_b1 = v;
        regen_f1 = v; regen_dcc = v; regen_rsv = v;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) m_trace[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_data == 8'h00 && out_fs == 1'b0, "R1",
              {out_fs, out_data}, 9'h000);
        rst_n = 1'b1;

        set_regen(1); scr_en = 0; j0_short = 1;
        // R4: load the trace table during the first frame
        for (int a = 0; a < 64; a++) begin
            trace_we = 1; trace_addr = 6'(a); trace_wdata = 8'($urandom);
            send(8'($urandom));
        end
        trace_we = 0;
        for (int i = 64; i < FRAME; i++) send(8'($urandom));
        frames(3);                                   // R2 R4 R6 R8 R9 R10
        scr_en = 1; frames(2);                       // R12
        set_regen(0); frames(1);                     // pass-through of all groups
        set_regen(1); frm_err = 1; b1_err = 1; frames(2);   // R3 R7
        frm_err = 0; b1_err = 0;
        ais_man = 1; rs_ais_en = 1; frames(1);       // R5 R11
        rs_ais_en = 0; scr_en = 0; frames(1);        // R11 unscrambled
        ais_man = 0; ais_auto_en = 1; lof = 1; frames(1);   // R11 auto
        lof = 0; los = 1; rs_ais_en = 1; frames(1);
        ais_auto_en = 0; lof = 1; frames(1);         // R11: defects ignored
        lof = 0; los = 0; scr_en = 1;
        // R1: early frame marker
        for (int i = 0; i < 317; i++) send(8'($urandom));
        g_pos = 0;
        frames(2);
        // R4: long trace wraps after 64 frames
        j0_short = 0; frames(66);
        j0_short = 1;
        // random control mix
        for (int f = 0; f < 30; f++) begin
            regen_a1a2 = 1'($urandom); regen_j0 = 1'($urandom);
            regen_b1 = 1'($urandom);   regen_f1 = 1'($urandom);
            regen_dcc = 1'($urandom);  regen_rsv = 1'($urandom);
            frm_err = ($urandom % 4) == 0; b1_err = ($urandom % 4) == 0;
            ais_man = ($urandom % 5) == 0; ais_auto_en = 1'($urandom);
            lof = ($urandom % 4) == 0; los = ($urandom % 4) == 0;
            rs_ais_en = 1'($urandom); j0_short = 1'($urandom);
            scr_en = 1'($urandom);
            frames(1);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule